// File: doc/BRIEF.md
# Deferred Soft-Stop Reset Controller

This block sits beside the control/status registers of a bus-mastering network controller. It turns a software write to the stop bit into a local reset. A write begins a stop event only when it moves the stop bit from zero to one. The event is not carried out at once. The block holds it until the bus-master engine owns the bus and has finished every master access it had queued. It then pulses, for one clock, a reset into a chosen subset of status registers and into the internal sequencer.

While an event is held, the block keeps the bus request alive for the accesses that still remain. Configuration registers, the transceiver control and the EEPROM loader are left alone. The EEPROM load request fires only once, after hardware reset, and never after a stop. A pending flag lets logic or a bench observe the window between the write and the reset.

Top module: `stop_reset_ctl`

## Requirements
- R1: A write with `wrEn`=1, `wrAddr`=0 and `wrData` bit 2 set, while `stopActive` is 0, makes `stopActive` and `stopPending` both 1 from the next clock edge.
- R2: The same write while `stopActive` is already 1 starts no event: `stopPending` stays 0 and no reset pulse follows.
- R3: While pending, the reset pulse is issued only after an edge at which `busGnt`=1 and `pendCnt`=0 were both sampled. It appears in the cycle right after that edge.
- R4: The reset pulse lasts exactly one clock. During it `seqRst`=1 and `regRst` equals the mask with bits 0, 3 and 4 set and every other bit clear.
- R5: `busReqOut` equals `busReqIn` OR (`stopPending` AND `pendCnt`≠0), so a pending stop never withdraws the request while accesses remain.
- R6: `stopActive` stays 1 after the reset pulse. It clears only when bit 2 of address 0 is written as 0 with no event outstanding. A zero written there while pending is ignored.
- R7: Writes to the suspend bit (address 5, bit 0), writes to other addresses, and writes to address 0 with bit 2 clear start no event.
- R8: `eeLoadReq` pulses for exactly one cycle, in the first cycle after reset release, and never again because of a stop.
- R9: While `rstN` is low, `stopActive`, `stopPending`, `seqRst`, `regRst` and `eeLoadReq` are all 0.
- R10: Stop writes that arrive while an event is pending are ignored, so at most one reset pulse follows one starting write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (4) | Register index of the write |
| wrData | input | DATA_W (16) | Write data |
| busReqIn | input | 1 | Bus request from the master engine |
| busGnt | input | 1 | Bus grant to the master engine |
| pendCnt | input | CNT_W (4) | Count of queued master accesses |
| busReqOut | output | 1 | Bus request presented to the arbiter |
| regRst | output | NUM_REGS (8) | Per-register reset pulses |
| seqRst | output | 1 | Sequencer reset pulse |
| stopActive | output | 1 | Current value of the stop bit |
| stopPending | output | 1 | Stop event held, waiting for drain |
| eeLoadReq | output | 1 | EEPROM load request after hardware reset |

## Verification
The assertions assume that `pendCnt` and `busGnt` are stable around the clock edge. They also assume that `busGnt` may rise while accesses are still queued, so grant alone must never be enough to fire. The stimulus changes every input only at the falling edge. It deliberately raises grant while the count is nonzero and lowers the request mid-drain, so the hold-off and request-keep properties are exercised on both sides.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_FIRE = 2'd2
  } stopState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setStop;   // latch stop bit, event accepted
    logic allowClr;  // software may clear the stop bit
    logic holdReq;   // keep bus request alive for queued work
    logic fire;      // one-cycle local reset
  } stopStrobe_t;

endpackage

// File: rtl/stopctl_datapath.sv
module stopctl_datapath
  import stopctl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 4,
  parameter int NUM_REGS  = 8,
  parameter int CTL_ADDR  = 0,
  parameter int STOP_POS  = 2,
  parameter logic [NUM_REGS-1:0] RST_MASK = 8'b0001_1001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busReqIn,
  input  logic [CNT_W-1:0]  pendCnt,
  input  stopStrobe_t       strobes,
  output logic              stopWrOne,
  output logic              stopWrZero,
  output logic              stopBitQ,
  output logic              drainDone,
  output logic              busReqOut,
  output logic [NUM_REGS-1:0] regRst,
  output logic              seqRst,
  output logic              eeLoadReq
);

  localparam logic [ADDR_W-1:0] CtlAddr = ADDR_W'(CTL_ADDR);

  logic ctlHit;
  logic eeArmed;
  logic eeReqQ;

  assign ctlHit     = wrEn && (wrAddr == CtlAddr);
  assign stopWrOne  = ctlHit &&  wrData[STOP_POS];
  assign stopWrZero = ctlHit && !wrData[STOP_POS];
  assign drainDone  = (pendCnt == '0);

  // stop bit: set on accepted event, cleared only when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopBitQ <= 1'b0;
    end else if (strobes.setStop) begin
      stopBitQ <= 1'b1;
    end else if (stopWrZero && strobes.allowClr) begin
      stopBitQ <= 1'b0;
    end
  end

  // request is never dropped while queued work remains
  assign busReqOut = busReqIn || (strobes.holdReq && !drainDone);

  // per-register reset pulses
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_regRst
      if (RST_MASK[g]) begin : g_sel
        assign regRst[g] = strobes.fire;
      end else begin : g_keep
        assign regRst[g] = 1'b0;
      end
    end
  endgenerate

  assign seqRst = strobes.fire;

  // EEPROM load only once after hardware reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eeArmed <= 1'b0;
      eeReqQ  <= 1'b0;
    end else begin
      eeArmed <= 1'b1;
      eeReqQ  <= !eeArmed;
    end
  end
  assign eeLoadReq = eeReqQ;

  // R5
  // queued work holds the outgoing request
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.holdReq && !drainDone) |-> busReqOut);

  // R8
  // load request is a single-cycle pulse
  ee_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeLoadReq |=> !eeLoadReq);

  // R6
  // stop bit cannot drop while a reset is being fired
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> stopBitQ);

endmodule

// File: rtl/stopctl_fsm.sv
module stopctl_fsm
  import stopctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopWrOne,
  input  logic        stopBitQ,
  input  logic        busGnt,
  input  logic        drainDone,
  output stopStrobe_t strobes,
  output logic        pendingSts
);

  stopState_e state, stateNxt;
  logic       startEvt;

  assign startEvt = (state == ST_IDLE) && stopWrOne && !stopBitQ;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (startEvt)            stateNxt = ST_PEND;
      ST_PEND: if (busGnt && drainDone) stateNxt = ST_FIRE;
      ST_FIRE:                          stateNxt = ST_IDLE;
      default:                          stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes.setStop  = startEvt;
    strobes.allowClr = (state == ST_IDLE);
    strobes.holdReq  = (state == ST_PEND);
    strobes.fire     = (state == ST_FIRE);
  end

  assign pendingSts = (state == ST_PEND);

  // R1
  // zero-to-one stop write opens a pending event
  start_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stopWrOne && !stopBitQ) |=> pendingSts);

  // R3
  // fire only after grant seen with nothing queued
  fire_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.fire) |-> $past(busGnt && drainDone));

  // R4
  // reset pulse is one clock wide
  fire_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> !strobes.fire);

  // R10
  // pending implies the stop bit is already held
  pend_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingSts |-> stopBitQ);

endmodule

// File: rtl/stop_reset_ctl.sv
module stop_reset_ctl
  import stopctl_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 4,
  parameter int NUM_REGS = 8,
  parameter int CTL_ADDR = 0,
  parameter int STOP_POS = 2,
  parameter logic [NUM_REGS-1:0] RST_MASK = 8'b0001_1001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                busReqIn,
  input  logic                busGnt,
  input  logic [CNT_W-1:0]    pendCnt,
  output logic                busReqOut,
  output logic [NUM_REGS-1:0] regRst,
  output logic                seqRst,
  output logic                stopActive,
  output logic                stopPending,
  output logic                eeLoadReq
);

  stopStrobe_t strobes;
  logic stopWrOne, stopWrZero, stopBitQ, drainDone;

  stopctl_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .stopWrOne  (stopWrOne),
    .stopBitQ   (stopBitQ),
    .busGnt     (busGnt),
    .drainDone  (drainDone),
    .strobes    (strobes),
    .pendingSts (stopPending)
  );

  stopctl_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .NUM_REGS (NUM_REGS),
    .CTL_ADDR (CTL_ADDR),
    .STOP_POS (STOP_POS),
    .RST_MASK (RST_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .busReqIn   (busReqIn),
    .pendCnt    (pendCnt),
    .strobes    (strobes),
    .stopWrOne  (stopWrOne),
    .stopWrZero (stopWrZero),
    .stopBitQ   (stopBitQ),
    .drainDone  (drainDone),
    .busReqOut  (busReqOut),
    .regRst     (regRst),
    .seqRst     (seqRst),
    .eeLoadReq  (eeLoadReq)
  );

  assign stopActive = stopBitQ;

endmodule

// File: tb/test_stop_reset_ctl.sv
module test_stop_reset_ctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EXP_MASK = 8'b0001_1001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic busReqIn = 1'b0;
  logic busGnt = 1'b0;
  logic [3:0] pendCnt = '0;
  logic busReqOut, seqRst, stopActive, stopPending, eeLoadReq;
  logic [7:0] regRst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int eeCount = 0;
  bit monOn = 1'b0;
  int expQ[$];

  stop_reset_ctl i_stop_reset_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busReqIn(busReqIn), .busGnt(busGnt), .pendCnt(pendCnt),
    .busReqOut(busReqOut), .regRst(regRst), .seqRst(seqRst),
    .stopActive(stopActive), .stopPending(stopPending), .eeLoadReq(eeLoadReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  // expect a reset pulse in the cycle after the next edge
  task automatic expectFire();
    expQ.push_back(cyc + 1);
  endtask

  // monitor: scoreboard of reset pulses and EEPROM requests
  always @(negedge clk) begin
    if (monOn) begin
      if (eeLoadReq) eeCount++;
      if (seqRst) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected pulse", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          chk(e == cyc, "R3 pulse cycle", cyc, e);
          chk(regRst == EXP_MASK, "R4 mask", int'(regRst), int'(EXP_MASK));
          chk(!stopPending, "R4 pending off in pulse", int'(stopPending), 0);
        end
      end else begin
        chk(regRst == 8'h00, "R4 no stray regRst", int'(regRst), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) step();
    chk(!stopActive && !stopPending && !seqRst && regRst == 0 && !eeLoadReq,
        "R9 reset outputs", int'({stopActive, stopPending, seqRst, eeLoadReq}), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    step();
    chk(eeLoadReq, "R8 ee pulse after reset", int'(eeLoadReq), 1);
    step();
    chk(!eeLoadReq, "R8 ee pulse ends", int'(eeLoadReq), 0);

    // R7 no trigger from suspend, other address, or bit clear
    busGnt = 1'b1; pendCnt = 0;
    wr(4'd5, 16'h0001);
    chk(!stopPending && !stopActive, "R7 suspend write", int'(stopPending), 0);
    wr(4'd3, 16'h0004);
    chk(!stopPending && !stopActive, "R7 other address", int'(stopPending), 0);
    wr(4'd0, 16'hFFFB);
    chk(!stopPending && !stopActive, "R7 bit2 clear", int'(stopPending), 0);
    step();

    // R1 start with grant absent and work queued
    busGnt = 1'b0; pendCnt = 4'd3; busReqIn = 1'b1;
    wr(4'd0, 16'h0004);
    chk(stopActive && stopPending, "R1 start event", int'({stopActive, stopPending}), 3);

    // R5 request kept while queued work remains
    busReqIn = 1'b0; #1;
    chk(busReqOut, "R5 request held", int'(busReqOut), 1);

    // R3 grant without drain does not fire
    busGnt = 1'b1;
    step();
    chk(stopPending, "R3 grant with work queued", int'(stopPending), 1);

    // R10 repeated stop write while pending
    wr(4'd0, 16'h0004);
    chk(stopPending, "R10 still single pending", int'(stopPending), 1);
    // R6 zero write while pending ignored
    wr(4'd0, 16'h0000);
    chk(stopActive, "R6 zero while pending", int'(stopActive), 1);

    // R3 drained but no grant does not fire
    busGnt = 1'b0; pendCnt = 0;
    step();
    chk(stopPending, "R3 drained without grant", int'(stopPending), 1);
    #1;
    chk(!busReqOut, "R5 request follows input once drained", int'(busReqOut), 0);

    // R3 fire
    busGnt = 1'b1;
    expectFire();
    step();
    step();
    chk(!seqRst && !stopPending, "R4 pulse ended", int'(seqRst), 0);
    chk(stopActive, "R6 stop bit kept after reset", int'(stopActive), 1);

    // R2 one written while already set
    wr(4'd0, 16'h0004);
    chk(!stopPending, "R2 no restart", int'(stopPending), 0);
    repeat (3) step();

    // R6 clear in idle
    wr(4'd0, 16'h0000);
    chk(!stopActive, "R6 clear when idle", int'(stopActive), 0);

    // immediate fire: grant and empty queue already present
    wr(4'd0, 16'h0004);
    chk(stopPending, "R1 second start", int'(stopPending), 1);
    expectFire();
    step();
    repeat (3) step();

    // R5 plain pass-through in idle
    busReqIn = 1'b1; #1;
    chk(busReqOut, "R5 passthrough", int'(busReqOut), 1);

    chk(expQ.size() == 0, "R3 all pulses seen", expQ.size(), 0);
    chk(eeCount == 1, "R8 ee once only", eeCount, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule